// File: doc/BRIEF.md
# Multi-mode LED chaser controller

This block drives a row of eight LEDs in one of three moving patterns. A two-bit switch input picks the pattern. A cycle-counting prescaler fires a one-cycle step enable roughly every 0.3 s at a 50 MHz system clock, which is a terminal count of 15,000,000. Each step enable moves the LED register one position along the selected pattern. Every register runs on the system clock, and no divided clock is ever used as a clock.

The switch value passes through a two-flop synchronizer before use. A change in the synchronized value is a *restart*. On the next clock edge the pattern goes to its mode's starting picture, and the prescaler goes back to zero. The pattern engine is a four-state machine. The states are:
- `PS_TWIST`: twisted ring, used for modes 00 and 11.
- `PS_ROTATE`: one lit LED rotating.
- `PS_BOUNCE_UP`: one lit LED bouncing, moving toward LED7.
- `PS_BOUNCE_DOWN`: one lit LED bouncing, moving toward LED0.

The transitions are:
- *restart*: from any state to the entry state of the new mode.
- *reverse-up*: `PS_BOUNCE_UP` goes to `PS_BOUNCE_DOWN` on a step taken while LED7 is lit.
- *reverse-down*: `PS_BOUNCE_DOWN` goes to `PS_BOUNCE_UP` on a step taken while LED0 is lit.
- *hold*: every other step keeps the state.

Reset puts the machine in `PS_TWIST` with all LEDs off and the prescaler at zero. A bounce always begins in the upward direction. The terminal count is a parameter, so that a short count can be used in simulation.

Top module: `led_chaser_top`

## Requirements
- R1: Reset (`rst` high) turns all LEDs off and sets the prescaler to zero. The first step after reset is released lands on the TERM_COUNT-th rising edge after release, in mode 00.
- R2: The LEDs change only on a step or on a restart. Steps are exactly TERM_COUNT clock cycles apart while the mode is unchanged.
- R3: In mode 2'b00 each step shifts every LED into its upper neighbour, and LED0 takes the inverse of LED7. Starting from all off, the sequence returns to all off after 16 steps.
- R4: In mode 2'b01 a single lit LED moves from bit 0 toward bit 7 on each step, and bit 7 wraps to bit 0.
- R5: In mode 2'b10 a single lit LED moves up one bit per step. On a step taken while bit 7 is lit, it moves down to bit 6 instead. It then moves down until a step taken while bit 0 is lit moves it to bit 1.
- R6: Mode 2'b11 behaves exactly as mode 2'b00, including its all-off start and its 16-step cycle.
- R7: A switch change reaches the pattern through two synchronizer flops. The restart picture appears on the third rising edge after the new switch value is applied.
- R8: On a restart the LEDs load the starting picture of the new mode. That picture is all off for 00 and 11, and only bit 0 lit for 01 and 10. The prescaler clears, so the first step follows TERM_COUNT edges after the restart edge.
- R9: When a restart and a step fall on the same edge, the restart wins and the step is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 50 MHz |
| rst | input | 1 | Synchronous reset, active high |
| sw_mode | input | 2 | Mode switches, asynchronous to `clk` |
| led | output | LED_W (8) | LED drive, bit 0 is LED0 |

## Verification
The two functions that can land on one edge are the restart from a switch change and the prescaler step. The bench sets up the collision on purpose. It waits for a step in rotate mode, then applies the new switch value exactly three edges before the next scheduled step, so that the restart lands on that step edge. The collision is judged correct when the LEDs show the new mode's starting picture instead of the advanced rotate picture, and the following step arrives a full TERM_COUNT edges later. Random switch changes held for shorter than one step interval also hit the same collision, and a cycle-level reference model checks every such case.

// File: rtl/chaser_pkg.sv
package chaser_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_TWIST     = 2'b00,
        MODE_ROTATE    = 2'b01,
        MODE_BOUNCE    = 2'b10,
        MODE_TWIST_ALT = 2'b11
    } mode_t;

    typedef enum logic [1:0] {
        PS_TWIST,
        PS_ROTATE,
        PS_BOUNCE_UP,
        PS_BOUNCE_DOWN
    } pat_state_t;

    // Entry state taken on a restart into the given mode.
    function automatic pat_state_t entry_state(input logic [MODE_W-1:0] m);
        pat_state_t s;
        case (m)
            MODE_ROTATE: s = PS_ROTATE;
            MODE_BOUNCE: s = PS_BOUNCE_UP;
            default:     s = PS_TWIST;
        endcase
        return s;
    endfunction

    // Single-dot modes start with LED0 lit; twisted ring starts dark.
    function automatic logic starts_lit(input logic [MODE_W-1:0] m);
        return (m == MODE_ROTATE) || (m == MODE_BOUNCE);
    endfunction

endpackage

// File: rtl/mode_sync.sv
module mode_sync
    import chaser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] sw_async,
    output logic [MODE_W-1:0] mode_s,
    output logic              restart
);

    logic [MODE_W-1:0] stage_a;
    logic [MODE_W-1:0] stage_b;
    logic [MODE_W-1:0] mode_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_a   <= '0;
            stage_b   <= '0;
            mode_last <= '0;
        end else begin
            stage_a   <= sw_async;
            stage_b   <= stage_a;
            mode_last <= stage_b;
        end
    end

    assign mode_s  = stage_b;
    assign restart = (stage_b != mode_last);

endmodule

// File: rtl/step_prescaler.sv
module step_prescaler #(
    parameter int TERM_COUNT = 15_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);

    localparam int CW = (TERM_COUNT > 2) ? $clog2(TERM_COUNT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TERM_COUNT - 1);

    logic [CW-1:0] count_q;

    assign tick = (count_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/pattern_engine.sv
module pattern_engine
    import chaser_pkg::*;
#(
    parameter int LED_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              tick,
    input  logic [MODE_W-1:0] mode,
    output pat_state_t        state,
    output logic [LED_W-1:0]  led
);

    localparam int TOP = LED_W - 1;

    pat_state_t       state_n;
    logic [LED_W-1:0] led_n;

    always_comb begin
        state_n = state;
        led_n   = led;
        if (restart) begin
            state_n = entry_state(mode);
            led_n   = starts_lit(mode) ? LED_W'(1) : '0;
        end else if (tick) begin
            unique case (state)
                PS_TWIST: begin
                    led_n = {led[TOP-1:0], ~led[TOP]};
                end
                PS_ROTATE: begin
                    led_n = {led[TOP-1:0], led[TOP]};
                end
                PS_BOUNCE_UP: begin
                    if (led[TOP]) begin
                        led_n   = led >> 1;
                        state_n = PS_BOUNCE_DOWN;
                    end else begin
                        led_n = led << 1;
                    end
                end
                PS_BOUNCE_DOWN: begin
                    if (led[0]) begin
                        led_n   = led << 1;
                        state_n = PS_BOUNCE_UP;
                    end else begin
                        led_n = led >> 1;
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_TWIST;
        end else begin
            state <= state_n;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            led <= '0;
        end else begin
            led <= led_n;
        end
    end

endmodule

// File: rtl/led_chaser_top.sv
module led_chaser_top
    import chaser_pkg::*;
#(
    parameter int LED_W      = 8,
    parameter int TERM_COUNT = 15_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       sw_mode,
    output logic [LED_W-1:0] led
);

    logic [MODE_W-1:0] mode_s;
    logic              restart;
    logic              tick;
    pat_state_t        state_q;

    mode_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .sw_async (sw_mode),
        .mode_s   (mode_s),
        .restart  (restart)
    );

    step_prescaler #(.TERM_COUNT(TERM_COUNT)) u_presc (
        .clk   (clk),
        .rst   (rst),
        .clear (restart),
        .tick  (tick)
    );

    pattern_engine #(.LED_W(LED_W)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (tick),
        .mode    (mode_s),
        .state   (state_q),
        .led     (led)
    );

endmodule

// File: rtl/chaser_checker.sv
module chaser_checker
    import chaser_pkg::*;
#(
    parameter int LED_W      = 8,
    parameter int TERM_COUNT = 15_000_000
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        sw_mode,
    input logic [MODE_W-1:0] mode_s,
    input logic              restart,
    input logic              tick,
    input pat_state_t        state,
    input logic [LED_W-1:0]  led
);

    logic       rst_q;
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R1: the edge after a reset cycle leaves every LED dark
    always_ff @(posedge clk) begin
        if (rst_q === 1'b1) begin
            p_reset_dark_r1: assert (led == '0);
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart) |=> $stable(led));

    // R4 and R5: dot modes keep exactly one LED lit
    p_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        (state != PS_TWIST) |-> ($countones(led) == 1));

    p_reverse_r5: assert property (@(posedge clk) disable iff (rst)
        (state == PS_BOUNCE_UP && led[LED_W-1] && tick && !restart)
        |=> (state == PS_BOUNCE_DOWN && led[LED_W-2]));

    p_sync_r7: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (mode_s == $past(sw_mode, 2)));

    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!tick &&
                     (led == ((($past(mode_s) == 2'b01) || ($past(mode_s) == 2'b10))
                              ? LED_W'(1) : LED_W'(0)))));

    p_prio_r9: assert property (@(posedge clk) disable iff (rst)
        (restart && tick) |=> (state == entry_state($past(mode_s))));

endmodule

bind led_chaser_top chaser_checker #(
    .LED_W      (LED_W),
    .TERM_COUNT (TERM_COUNT)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sw_mode (sw_mode),
    .mode_s  (mode_s),
    .restart (restart),
    .tick    (tick),
    .state   (state_q),
    .led     (led)
);

// File: tb/test_led_chaser_top.sv
module test_led_chaser_top;

    localparam int TC = 6;
    localparam int W  = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   sw  = 2'b00;
    logic [W-1:0] led;

    int compared   = 0;
    int mismatched = 0;
    int cyc        = 0;
    bit chk_on     = 1'b0;
    bit done       = 1'b0;

    always #10 clk = ~clk;

    led_chaser_top #(.LED_W(W), .TERM_COUNT(TC)) i_led_chaser_top (
        .clk     (clk),
        .rst     (rst),
        .sw_mode (sw),
        .led     (led)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // Reference model of one step, from the requirements. Returns {up, led}.
    function automatic logic [W:0] ref_step(input logic [1:0] m, input logic [W-1:0] l,
                                            input logic up);
        logic [W:0] r;
        case (m)
            2'b01: r = {up, l[W-2:0], l[W-1]};
            2'b10: begin
                if (up) r = l[W-1] ? {1'b0, l >> 1} : {1'b1, l << 1};
                else    r = l[0]   ? {1'b1, l << 1} : {1'b0, l >> 1};
            end
            default: r = {up, l[W-2:0], ~l[W-1]};
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [1:0] m);
        case (m)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    // Cycle-level expected-value model (inputs change only on negedges)
    logic [1:0]   m1, m2, mp;
    int           mcnt;
    logic [W-1:0] eled;
    logic         eup;

    always @(posedge clk) begin
        if (rst) begin
            m1 <= 2'b00; m2 <= 2'b00; mp <= 2'b00;
            mcnt <= 0; eled <= '0; eup <= 1'b1;
        end else begin
            m1 <= sw; m2 <= m1; mp <= m2;
            if (m2 != mp) begin
                mcnt <= 0;
                eled <= (m2 == 2'b01 || m2 == 2'b10) ? W'(1) : W'(0);
                eup  <= 1'b1;
            end else begin
                mcnt <= (mcnt == TC - 1) ? 0 : mcnt + 1;
                if (mcnt == TC - 1) {eup, eled} <= ref_step(m2, eled, eup);
            end
        end
    end

    always @(negedge clk) begin
        if (chk_on && !rst) check(tag_of(mp), led, eled);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            mismatched++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            finish_run();
        end
    end

    task automatic wait_change(output int n);
        logic [W-1:0] prev;
        prev = led;
        n = 0;
        do begin
            @(posedge clk); @(negedge clk); n++;
        end while (led == prev && n < 1000);
    endtask

    task automatic wait_for(input logic [W-1:0] v);
        int n;
        int k = 0;
        while (led != v && k < 40) begin
            wait_change(n);
            k++;
        end
    endtask

    initial begin
        int n;
        int steps;
        bit saw_full;
        void'($urandom(32'd51966));

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset dark", led, 0);
        rst = 1'b0;
        chk_on = 1'b1;
        wait_change(n);
        check("R1 first step edge", n, TC);
        check("R1 first step value", led, 8'h01);

        // R3: 16-step twisted ring
        steps = 1; saw_full = 0;
        while (led != 0 && steps < 40) begin
            wait_change(n);
            steps++;
            if (led == 8'hFF) saw_full = 1;
        end
        check("R3 cycle length", steps, 16);
        check("R3 all lit reached", saw_full, 1);

        // R7/R8: sync latency and restart
        sw = 2'b01;
        wait_for(8'h04);
        sw = 2'b10;
        n = 0;
        do begin @(posedge clk); @(negedge clk); n++; end while (led != 8'h01 && n < 50);
        check("R7 sync latency", n, 3);
        wait_change(n);
        check("R8 first step after restart", n, TC);
        check("R8 value after restart", led, 8'h02);

        // R5: bounce reversals
        wait_for(8'h80);
        wait_change(n);
        check("R5 reverse at top", led, 8'h40);
        wait_for(8'h01);
        wait_change(n);
        check("R5 reverse at bottom", led, 8'h02);

        // R2 and R9: restart colliding with a step
        sw = 2'b01;
        wait_for(8'h04);
        wait_change(n);
        check("R2 step interval", n, TC);
        check("R2 value", led, 8'h08);
        repeat (TC - 3) @(posedge clk);
        @(negedge clk);
        sw = 2'b10;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 restart beats step", led, 8'h01);
        wait_change(n);
        check("R9 step after collision", n, TC);
        check("R9 value after collision", led, 8'h02);

        // R4: wrap
        sw = 2'b01;
        wait_for(8'h80);
        wait_change(n);
        check("R4 wrap", led, 8'h01);

        // R6: mode 11
        sw = 2'b11;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 start dark", led, 0);
        steps = 0;
        do begin wait_change(n); steps++; end while (led != 0 && steps < 40);
        check("R6 cycle length", steps, 16);

        // Random switch activity, checked by the model
        for (int s = 0; s < 80; s++) begin
            sw = 2'($urandom_range(0, 3));
            repeat ($urandom_range(1, 40)) @(negedge clk);
        end
        repeat (100) @(negedge clk);
        finish_run();
    end

endmodule